// File: doc/BRIEF.md
# Lookup-Table Trigger Unit for a 16-Channel Logic Analyzer

This block decides, sample by sample, whether a 16-channel logic analyzer stream has reached its trigger condition. The channels are grouped into four nibbles, called quads. Each quad's four bits address a 16-entry truth table. Three functions each own one table per quad: a level (value/mask) match, edge unit 0 and edge unit 1. A function is true when every one of its quad tables returns 1.

The two edge-unit outputs are kept from the previous sample. The previous and current outputs of both units together address two 16-entry glue tables, a primary one and a secondary one. A final-stage 16-entry table then combines the primary glue bit, the secondary glue bit and the level match into the trigger decision. Because every condition is a truth table, software can express rise, fall, either edge, level or any OR/AND mix by filling tables alone.

Tables are loaded one entry index at a time through a byte-wide configuration port, and only while the unit is in programming mode. A host first enters programming mode. For each index it then writes two staged data bytes and a commit command. Finally it returns the unit to run mode.

Top module: `qlt_trigger`

## Requirements
- R1: Channel bits 4q+3..4q form the table index of quad q, with channel 4q as the index LSB. The level match is the AND over the four level tables, each addressed by its own quad.
- R2: Edge unit 0 and edge unit 1 each produce the AND of their own four quad tables, addressed in the same way as the level tables.
- R3: The glue index bits are: bit 0 = edge unit 0 current, bit 1 = edge unit 0 previous, bit 2 = edge unit 1 current, bit 3 = edge unit 1 previous. Both glue tables are read at this index.
- R4: The final-stage index bits are: bit 3 = primary glue bit, bit 2 = secondary glue bit, bit 1 = level match, bit 0 = 0. The trigger fires when the final-stage table holds 1 at that index.
- R5: In programming mode, configuration data writes (cfg_sel_i=0) alternate between two staging bytes, first byte then second. In the first byte, bits 3:0 are level quads 0..3, bit 4 is primary glue, bit 5 is secondary glue and bit 6 is final stage. In the second byte, bits 3:0 are edge-unit-0 quads and bits 7:4 are edge-unit-1 quads.
- R6: A command write (cfg_sel_i=1) of 0x30+k in programming mode stores the staged bytes into entry k of every table and rewinds the staging to the first byte. Outside programming mode, commit commands and data writes have no effect.
- R7: Command 0x2X enters programming mode. Command 0x0X returns to run mode. Commands with any other upper nibble are ignored.
- R8: In programming mode, strobed samples never trigger and both previous edge states are held at 0. The first sample after run mode resumes therefore sees previous = 0.
- R9: trig_o goes high for exactly one clock, the clock after a strobed sample that satisfies the trigger. It never goes high after an unstrobed sample.
- R10: fired_o is set together with trig_o and stays set. Entering programming mode clears it.
- R11: After reset all tables are zero, the unit is in run mode, and trig_o and fired_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 16 | Channel sample word |
| sample_vld_i | input | 1 | Sample strobe |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 = data byte, 1 = command byte |
| cfg_data_i | input | 8 | Configuration byte |
| trig_o | output | 1 | One-clock trigger pulse |
| fired_o | output | 1 | Sticky fired status |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:

- **Edge history across a mode change.** A rising-edge condition is armed, the channel is held high through programming mode, and the first sample after resuming must fire again. A design that kept stale history would stay silent instead.
- **Falling edge on the second unit.** A falling edge on edge unit 1 must fire, while its rising edge must not. Swapped glue index bits would report the wrong direction.
- **Writes outside programming mode.** Commit commands and data bytes sent in run mode must leave a working level trigger intact. A design that wrote anyway would stop firing.
- **Idle-state behaviour.** Unknown command nibbles, unstrobed samples and strobes during programming must produce no pulse.
- **Random tables.** Randomly filled tables driven with random samples cross-check the index bit orders of all three stages together.

// File: rtl/qlt_pkg.sv
package qlt_pkg;
  localparam int QW     = 4;            // channels per quad
  localparam int NQ     = 4;            // quads
  localparam int CH     = NQ * QW;      // channels
  localparam int ENT    = 1 << QW;      // entries per table
  localparam int NFUNC  = 3;            // level, edge0, edge1
  localparam int IW     = $clog2(ENT);
  localparam int F_VM   = 0;
  localparam int F_E0   = 1;
  localparam int F_E1   = 2;

  typedef logic [ENT-1:0] tbl_t;
  typedef tbl_t [NQ-1:0]  quad_tbl_t;

  localparam logic [3:0] CMD_RUN    = 4'h0;
  localparam logic [3:0] CMD_PROG   = 4'h2;
  localparam logic [3:0] CMD_COMMIT = 4'h3;
endpackage

// File: rtl/qlt_quad_and.sv
module qlt_quad_and
  import qlt_pkg::*;
(
  input  quad_tbl_t        tbl_i,
  input  logic [CH-1:0]    sample_i,
  output logic             hit_o
);
  logic [NQ-1:0] q_bit;

  for (genvar q = 0; q < NQ; q++) begin : g_quad
    assign q_bit[q] = tbl_i[q][sample_i[q*QW +: QW]];
  end

  assign hit_o = &q_bit;
endmodule

// File: rtl/qlt_cfg.sv
module qlt_cfg
  import qlt_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic                  sel_i,
  input  logic [7:0]            data_i,
  output logic                  prog_o,
  output logic                  enter_prog_o,
  output quad_tbl_t [NFUNC-1:0] qt_o,
  output tbl_t                  glue_o,
  output tbl_t                  glue2_o,
  output tbl_t                  fin_o
);
  logic                  prog_q, ptr_q;
  logic [7:0]            b0_q, b1_q;
  quad_tbl_t [NFUNC-1:0] qt_q;
  tbl_t                  glue_q, glue2_q, fin_q;

  logic [3:0]    cmd;
  logic [IW-1:0] idx;
  logic          cmd_wr, dat_wr, commit;

  assign cmd    = data_i[7:4];
  assign idx    = data_i[IW-1:0];
  assign cmd_wr = wr_i && sel_i;
  assign dat_wr = wr_i && !sel_i && prog_q;
  assign commit = cmd_wr && (cmd == CMD_COMMIT) && prog_q;

  assign enter_prog_o = cmd_wr && (cmd == CMD_PROG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q <= 1'b0;
      ptr_q  <= 1'b0;
      b0_q   <= '0;
      b1_q   <= '0;
    end else begin
      if (enter_prog_o) begin
        prog_q <= 1'b1;
        ptr_q  <= 1'b0;
      end else if (cmd_wr && cmd == CMD_RUN) begin
        prog_q <= 1'b0;
      end else if (commit) begin
        ptr_q  <= 1'b0;
      end else if (dat_wr) begin
        if (!ptr_q) b0_q <= data_i;
        else        b1_q <= data_i;
        ptr_q <= ~ptr_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qt_q    <= '0;
      glue_q  <= '0;
      glue2_q <= '0;
      fin_q   <= '0;
    end else if (commit) begin
      for (int q = 0; q < NQ; q++) begin
        qt_q[F_VM][q][idx] <= b0_q[q];
        qt_q[F_E0][q][idx] <= b1_q[q];
        qt_q[F_E1][q][idx] <= b1_q[NQ+q];
      end
      glue_q[idx]  <= b0_q[NQ];
      glue2_q[idx] <= b0_q[NQ+1];
      fin_q[idx]   <= b0_q[NQ+2];
    end
  end

  assign prog_o  = prog_q;
  assign qt_o    = qt_q;
  assign glue_o  = glue_q;
  assign glue2_o = glue2_q;
  assign fin_o   = fin_q;

  a_r6_commit_outside_prog_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && cmd == CMD_COMMIT && !prog_q) |=> ($stable(qt_q) && $stable(fin_q)));
  a_r6_commit_rewinds_staging: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> !ptr_q);
  a_r5_data_outside_prog_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sel_i && !prog_q) |=> ($stable(b0_q) && $stable(b1_q)));
  a_r7_enter_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_prog_o |=> prog_q);
endmodule

// File: rtl/qlt_core.sv
module qlt_core
  import qlt_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CH-1:0]         sample_i,
  input  logic                  valid_i,
  input  logic                  prog_i,
  input  logic                  enter_prog_i,
  input  quad_tbl_t [NFUNC-1:0] qt_i,
  input  tbl_t                  glue_i,
  input  tbl_t                  glue2_i,
  input  tbl_t                  fin_i,
  output logic                  trig_o,
  output logic                  fired_o
);
  logic [NFUNC-1:0] hit;

  for (genvar f = 0; f < NFUNC; f++) begin : g_func
    qlt_quad_and u_qa (
      .tbl_i    (qt_i[f]),
      .sample_i (sample_i),
      .hit_o    (hit[f])
    );
  end

  logic          e0_prev_q, e1_prev_q, trig_q, fired_q;
  logic [3:0]    gidx, fidx;
  logic          glue_bit, glue2_bit, fire, eval;

  assign gidx      = {e1_prev_q, hit[F_E1], e0_prev_q, hit[F_E0]};
  assign glue_bit  = glue_i[gidx];
  assign glue2_bit = glue2_i[gidx];
  assign fidx      = {glue_bit, glue2_bit, hit[F_VM], 1'b0};
  assign fire      = fin_i[fidx];
  assign eval      = valid_i && !prog_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e0_prev_q <= 1'b0;
      e1_prev_q <= 1'b0;
      trig_q    <= 1'b0;
      fired_q   <= 1'b0;
    end else begin
      trig_q <= eval && fire;
      if (prog_i) begin
        e0_prev_q <= 1'b0;
        e1_prev_q <= 1'b0;
      end else if (valid_i) begin
        e0_prev_q <= hit[F_E0];
        e1_prev_q <= hit[F_E1];
      end
      if (enter_prog_i)      fired_q <= 1'b0;
      else if (eval && fire) fired_q <= 1'b1;
    end
  end

  assign trig_o  = trig_q;
  assign fired_o = fired_q;

  a_r9_pulse_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |-> $past(valid_i));
  a_r8_no_trigger_in_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |=> !trig_q);
  a_r8_prev_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |=> (!e0_prev_q && !e1_prev_q));
  a_r10_fired_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired_q && !enter_prog_i) |=> fired_q);
  a_r10_trig_sets_fired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |-> fired_q);
endmodule

// File: rtl/qlt_trigger.sv
module qlt_trigger
  import qlt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [15:0]   sample_i,
  input  logic          sample_vld_i,
  input  logic          cfg_wr_i,
  input  logic          cfg_sel_i,
  input  logic [7:0]    cfg_data_i,
  output logic          trig_o,
  output logic          fired_o
);
  logic                  prog, enter_prog;
  quad_tbl_t [NFUNC-1:0] qt;
  tbl_t                  glue, glue2, fin;

  qlt_cfg u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (cfg_wr_i),
    .sel_i        (cfg_sel_i),
    .data_i       (cfg_data_i),
    .prog_o       (prog),
    .enter_prog_o (enter_prog),
    .qt_o         (qt),
    .glue_o       (glue),
    .glue2_o      (glue2),
    .fin_o        (fin)
  );

  qlt_core u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sample_i     (sample_i),
    .valid_i      (sample_vld_i),
    .prog_i       (prog),
    .enter_prog_i (enter_prog),
    .qt_i         (qt),
    .glue_i       (glue),
    .glue2_i      (glue2),
    .fin_i        (fin),
    .trig_o       (trig_o),
    .fired_o      (fired_o)
  );

  // R11: idle outputs right after reset release
  a_r11_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!trig_o && !fired_o));
endmodule

// File: tb/qlt_trigger_tb_top.sv
module qlt_trigger_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [15:0] sample = '0;
  logic       vld = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [7:0] cfg_data = '0;
  logic       trig, fired;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #5 clk = ~clk;

  qlt_trigger dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sample_vld_i(vld),
    .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .trig_o(trig), .fired_o(fired)
  );

  // model state
  logic [15:0] m_vm[4], m_e0[4], m_e1[4];
  logic [15:0] m_glue, m_glue2, m_fin;
  logic        m_prog, m_ptr, m_p0, m_p1, m_fired;
  logic [7:0]  m_b0, m_b1;
  // next configuration to load
  logic [15:0] n_vm[4], n_e0[4], n_e1[4];
  logic [15:0] n_glue, n_glue2, n_fin;

  function automatic logic hit_of(input int f, input logic [15:0] s);
    logic r = 1'b1;
    for (int q = 0; q < 4; q++) begin
      logic [3:0] nib = s[q*4 +: 4];
      if (f == 0) r &= m_vm[q][nib];
      else if (f == 1) r &= m_e0[q][nib];
      else r &= m_e1[q][nib];
    end
    return r;
  endfunction

  task automatic cfg_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    vld = 1'b0; cfg_wr = 1'b1; cfg_sel = sel; cfg_data = d;
    if (sel) begin
      if (d[7:4] == 4'h2) begin m_prog = 1; m_ptr = 0; m_fired = 0; end
      else if (d[7:4] == 4'h0) begin
        if (m_prog) begin m_p0 = 0; m_p1 = 0; end
        m_prog = 0;
      end else if (d[7:4] == 4'h3 && m_prog) begin
        for (int q = 0; q < 4; q++) begin
          m_vm[q][d[3:0]] = m_b0[q];
          m_e0[q][d[3:0]] = m_b1[q];
          m_e1[q][d[3:0]] = m_b1[4+q];
        end
        m_glue[d[3:0]]  = m_b0[4];
        m_glue2[d[3:0]] = m_b0[5];
        m_fin[d[3:0]]   = m_b0[6];
        m_ptr = 0;
      end
    end else if (m_prog) begin
      if (!m_ptr) m_b0 = d; else m_b1 = d;
      m_ptr = ~m_ptr;
    end
    @(posedge clk);
    #1 cfg_wr = 1'b0;
  endtask

  task automatic program_tables();
    cfg_write(1, 8'h20);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b0, b1;
      b0 = {1'b0, n_fin[i], n_glue2[i], n_glue[i], n_vm[3][i], n_vm[2][i], n_vm[1][i], n_vm[0][i]};
      b1 = {n_e1[3][i], n_e1[2][i], n_e1[1][i], n_e1[0][i], n_e0[3][i], n_e0[2][i], n_e0[1][i], n_e0[0][i]};
      cfg_write(0, b0);
      cfg_write(0, b1);
      cfg_write(1, 8'h30 | 8'(i));
    end
    cfg_write(1, 8'h00);
  endtask

  task automatic step(input logic [15:0] s, input logic v, input string req);
    logic e0c, e1c, exp_t;
    logic [3:0] gi, fi;
    @(negedge clk);
    cfg_wr = 1'b0; sample = s; vld = v;
    e0c = hit_of(1, s);
    e1c = hit_of(2, s);
    gi = {m_p1, e1c, m_p0, e0c};
    fi = {m_glue[gi], m_glue2[gi], hit_of(0, s), 1'b0};
    exp_t = v && !m_prog && m_fin[fi];
    if (m_prog) begin m_p0 = 0; m_p1 = 0; end
    else if (v) begin m_p0 = e0c; m_p1 = e1c; end
    if (exp_t) m_fired = 1;
    @(posedge clk);
    #2;
    vectors++;
    if (trig !== exp_t || fired !== m_fired) begin
      miscompares++;
      $display("FAIL %s: sample=%h trig_o=%b fired_o=%b expected trig=%b fired=%b",
               req, s, trig, fired, exp_t, m_fired);
    end
    vld = 1'b0;
  endtask

  task automatic clear_next();
    for (int q = 0; q < 4; q++) begin n_vm[q] = '0; n_e0[q] = '0; n_e1[q] = '0; end
    n_glue = '0; n_glue2 = '0; n_fin = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, observed done=0 expected done=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h51C0_7A11));
    for (int q = 0; q < 4; q++) begin m_vm[q] = '0; m_e0[q] = '0; m_e1[q] = '0; end
    m_glue = '0; m_glue2 = '0; m_fin = '0;
    m_prog = 0; m_ptr = 0; m_p0 = 0; m_p1 = 0; m_fired = 0; m_b0 = '0; m_b1 = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state: zero tables never fire
    vectors++;
    if (trig !== 1'b0 || fired !== 1'b0) begin
      miscompares++;
      $display("FAIL R11: trig_o=%b fired_o=%b expected 0 0", trig, fired);
    end
    step(16'hFFFF, 1, "R11");

    // R1/R4: exact level match on 0xA5C3
    clear_next();
    n_vm[0] = 16'h0008; n_vm[1] = 16'h1000; n_vm[2] = 16'h0020; n_vm[3] = 16'h0400;
    for (int q = 0; q < 4; q++) begin n_e0[q] = 16'hFFFF; n_e1[q] = 16'hFFFF; end
    n_glue = 16'hFFFF; n_fin = 16'hCCCC;
    program_tables();
    step(16'hA5C2, 1, "R1");
    step(16'hA5C3, 1, "R1");
    step(16'hA5C3, 0, "R9");
    step(16'h25C3, 1, "R4");

    // R6: commit and data in run mode ignored
    cfg_write(0, 8'h00);
    cfg_write(0, 8'h00);
    cfg_write(1, 8'h3A);
    cfg_write(1, 8'h33);
    step(16'hA5C3, 1, "R6");

    // R7: unknown command ignored, fired kept
    cfg_write(1, 8'h5F);
    step(16'hA5C3, 1, "R7");

    // R8/R10: programming mode blocks evaluation and clears fired
    cfg_write(1, 8'h2F);
    step(16'hA5C3, 1, "R10");
    cfg_write(1, 8'h1F);
    step(16'hA5C3, 1, "R8");
    cfg_write(1, 8'h00);
    step(16'hA5C3, 1, "R8");

    // R2/R3: rise on ch5 (edge unit 0) OR fall on ch12 (edge unit 1)
    clear_next();
    for (int q = 0; q < 4; q++) begin n_vm[q] = 16'hFFFF; n_e0[q] = 16'hFFFF; n_e1[q] = 16'hFFFF; end
    for (int j = 0; j < 16; j++) begin
      n_e0[1][j] = j[1];
      n_e1[3][j] = j[0];
      n_glue[j]  = ((j & 3) == 1) || (((j >> 2) & 3) == 2);
    end
    n_fin = 16'hCC00;
    program_tables();
    step(16'h0020, 1, "R8");
    step(16'h0020, 1, "R3");
    step(16'h0000, 1, "R3");
    step(16'h0020, 1, "R2");
    step(16'h1020, 1, "R3");
    step(16'h1000, 1, "R3");
    step(16'h0000, 1, "R2");
    step(16'h0020, 0, "R9");
    step(16'h0020, 1, "R9");
    cfg_write(1, 8'h20);
    step(16'h0020, 1, "R8");
    cfg_write(1, 8'h00);
    step(16'h0020, 1, "R8");

    // R5: staging pointer rewinds after commit, third data byte wraps
    cfg_write(1, 8'h20);
    cfg_write(0, 8'h7F);
    cfg_write(0, 8'hFF);
    cfg_write(0, 8'h40);
    cfg_write(0, 8'hFF);
    cfg_write(1, 8'h30);
    cfg_write(1, 8'h00);
    step(16'h0000, 1, "R5");
    step(16'h0011, 1, "R5");

    // random tables and samples, all requirements
    for (int r = 0; r < 6; r++) begin
      for (int q = 0; q < 4; q++) begin
        n_vm[q] = 16'($urandom) | 16'($urandom);
        n_e0[q] = 16'($urandom) | 16'($urandom);
        n_e1[q] = 16'($urandom) | 16'($urandom);
      end
      n_glue = 16'($urandom); n_glue2 = 16'($urandom); n_fin = 16'($urandom);
      program_tables();
      for (int k = 0; k < 250; k++) begin
        step(16'($urandom), ($urandom % 4) != 0, "R4");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule